// File: doc/BRIEF.md
# Grouped hybrid tree multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. Each operand is cut into a low and a high nibble, which gives four independent 4×4 partial-product groups: low×low, low×high, high×low and high×high. Every group forms its sixteen partial-product bits with two-input AND gates. Each group then reduces them in its own gate-level tree of half and full adders. The two groups on the diagonal (low×low and high×high) use a height-targeted reduction of the Dadda kind. The two cross groups use a layered reduction of the Wallace kind. All four trees work side by side.

The four 8-bit group results are placed at their weights: low×low at bit 0, the cross groups at bit 4, and high×high at bit 8. A merge row adds them. This row is built from five-input cells, each made of two cascaded full adders, and it ends in a short half-adder tail. Every adder is an explicit cell instance, so the reduction structure can be seen in the netlist. The product goes into an output register with a synchronous, active-high reset, so a result appears one clock after its operands.

Top module: `gdm_mult`

## Requirements
- R1: `prod_o` holds the unsigned product of the `a_i` and `b_i` values sampled at the previous rising clock edge, which is a latency of one cycle.
- R2: While `rst` is high at a rising edge, `prod_o` becomes zero, whatever the operands are.
- R3: When both high nibbles (bits 7:4) are zero, the low×low group alone sets the result, which is `a_i[3:0]*b_i[3:0]` in bits 7:0 with bits 15:8 zero.
- R4: When both low nibbles (bits 3:0) are zero, the result is `(a_i[7:4]*b_i[7:4]) << 8`, and bits 7:0 are zero.
- R5: When one operand has only its low nibble set and the other only its high nibble, the result is the cross-group product shifted left by 4.
- R6: The merge row carries correctly across all 16 bits. 0xB6×0x9C gives 0x6EE8, 0xF0×0x0F gives 0x0E10, and 0xFF×0xFF gives 0xFE01.
- R7: If either operand is zero, the product is zero.
- R8: The result is exact for all 65536 operand pairs.
- R9: `prod_o` never exceeds 0xFE01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset; clears the product |
| a_i | input | 8 | Unsigned multiplicand |
| b_i | input | 8 | Unsigned multiplier |
| prod_o | output | 16 | Registered unsigned product |

## Verification
The assertions compare each group tree and the merge row against arithmetic on the sampled operands. For that they take the operands to be fully known (no X or Z) and settled before every rising edge, and they take reset to be held for at least one edge before checking starts. The bench keeps within these limits. It drives defined operand values from time zero and changes them only on falling edges, and it holds reset over several edges before releasing it. The directed cases isolate each group by zeroing nibbles. An exhaustive sweep then covers every operand pair once.

// File: rtl/gdm_pkg.sv
package gdm_pkg;
  localparam int NIB  = 4;          // nibble width of a group operand
  localparam int OPW  = 2 * NIB;    // operand width
  localparam int PW   = 2 * OPW;    // product width
  localparam int NGRP = 4;          // number of partial-product groups
  typedef logic [NIB-1:0][NIB-1:0] pp_t;   // pp[i][j] has weight i+j
  typedef logic [OPW-1:0]          grp_t;  // one group's reduced result
endpackage

// File: rtl/gdm_cells.sv
module gdm_ha (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

module gdm_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  logic xy;
  assign xy = x ^ y;
  assign s  = xy ^ z;
  assign c  = (x & y) | (z & xy);
endmodule

// Five-input counter cell: three column bits plus two carries from the column below.
// The first adder sees only column bits, so only the second adder lies on the ripple path.
module gdm_c52 (
  input  logic x0,
  input  logic x1,
  input  logic x2,
  input  logic ci_a,
  input  logic ci_b,
  output logic s,
  output logic co_a,
  output logic co_b
);
  logic s_mid;
  gdm_fa u_fa0 (.x(x0), .y(x1), .z(x2), .s(s_mid), .c(co_a));
  gdm_fa u_fa1 (.x(s_mid), .y(ci_a), .z(ci_b), .s(s), .c(co_b));
endmodule

// File: rtl/gdm_ppgen.sv
module gdm_ppgen
  import gdm_pkg::*;
(
  input  logic [NIB-1:0] a_nib,
  input  logic [NIB-1:0] b_nib,
  output pp_t            pp
);
  for (genvar i = 0; i < NIB; i++) begin : g_row
    for (genvar j = 0; j < NIB; j++) begin : g_col
      assign pp[i][j] = a_nib[i] & b_nib[j];
    end
  end
endmodule

// File: rtl/gdm_dadda4.sv
// Height-targeted reduction of a 4x4 group: max height 4 -> 3 -> 2, then ripple.
module gdm_dadda4
  import gdm_pkg::*;
(
  input  pp_t  pp,
  output grp_t res
);
  // stage 1: bring columns 3 and 4 down to height 3
  logic d3, k4a, d4, k5a;
  gdm_ha u_s1c3 (.x(pp[0][3]), .y(pp[1][2]), .s(d3), .c(k4a));
  gdm_ha u_s1c4 (.x(pp[1][3]), .y(pp[2][2]), .s(d4), .c(k5a));

  // stage 2: bring every column down to height 2
  logic e2, k3, e3, k4, e4, k5, e5, k6;
  gdm_ha u_s2c2 (.x(pp[0][2]), .y(pp[1][1]), .s(e2), .c(k3));
  gdm_fa u_s2c3 (.x(d3), .y(pp[2][1]), .z(pp[3][0]), .s(e3), .c(k4));
  gdm_fa u_s2c4 (.x(d4), .y(pp[3][1]), .z(k4a), .s(e4), .c(k5));
  gdm_fa u_s2c5 (.x(pp[2][3]), .y(pp[3][2]), .z(k5a), .s(e5), .c(k6));

  // final two-row ripple
  logic q2, q3, q4, q5, q6;
  assign res[0] = pp[0][0];
  gdm_ha u_r1 (.x(pp[0][1]), .y(pp[1][0]), .s(res[1]), .c(q2));
  gdm_fa u_r2 (.x(e2), .y(pp[2][0]), .z(q2), .s(res[2]), .c(q3));
  gdm_fa u_r3 (.x(e3), .y(k3), .z(q3), .s(res[3]), .c(q4));
  gdm_fa u_r4 (.x(e4), .y(k4), .z(q4), .s(res[4]), .c(q5));
  gdm_fa u_r5 (.x(e5), .y(k5), .z(q5), .s(res[5]), .c(q6));
  gdm_fa u_r6 (.x(pp[3][3]), .y(k6), .z(q6), .s(res[6]), .c(res[7]));
endmodule

// File: rtl/gdm_wallace4.sv
// Layered reduction of a 4x4 group: every column of 2 or 3 is compressed per layer.
module gdm_wallace4
  import gdm_pkg::*;
(
  input  pp_t  pp,
  output grp_t res
);
  // layer 1
  logic w1, h2, w2, h3, w3, h4, w4, h5, w5, h6;
  gdm_ha u_l1c1 (.x(pp[0][1]), .y(pp[1][0]), .s(w1), .c(h2));
  gdm_fa u_l1c2 (.x(pp[0][2]), .y(pp[1][1]), .z(pp[2][0]), .s(w2), .c(h3));
  gdm_fa u_l1c3 (.x(pp[0][3]), .y(pp[1][2]), .z(pp[2][1]), .s(w3), .c(h4));
  gdm_fa u_l1c4 (.x(pp[1][3]), .y(pp[2][2]), .z(pp[3][1]), .s(w4), .c(h5));
  gdm_ha u_l1c5 (.x(pp[2][3]), .y(pp[3][2]), .s(w5), .c(h6));

  // layer 2 (pp[3][0] passed down from layer 1 into column 3)
  logic x2, g3, x3, g4, x4, g5, x5, g6, x6, g7;
  gdm_ha u_l2c2 (.x(w2), .y(h2), .s(x2), .c(g3));
  gdm_fa u_l2c3 (.x(w3), .y(h3), .z(pp[3][0]), .s(x3), .c(g4));
  gdm_ha u_l2c4 (.x(w4), .y(h4), .s(x4), .c(g5));
  gdm_ha u_l2c5 (.x(w5), .y(h5), .s(x5), .c(g6));
  gdm_ha u_l2c6 (.x(pp[3][3]), .y(h6), .s(x6), .c(g7));

  // final two-row ripple
  logic q4, q5, q6, q7;
  assign res[0] = pp[0][0];
  assign res[1] = w1;
  assign res[2] = x2;
  gdm_ha u_r3 (.x(x3), .y(g3), .s(res[3]), .c(q4));
  gdm_fa u_r4 (.x(x4), .y(g4), .z(q4), .s(res[4]), .c(q5));
  gdm_fa u_r5 (.x(x5), .y(g5), .z(q5), .s(res[5]), .c(q6));
  gdm_fa u_r6 (.x(x6), .y(g6), .z(q6), .s(res[6]), .c(q7));
  // a 4x4 product fits in 8 bits, so g7 and q7 are never both set
  assign res[7] = g7 | q7;
endmodule

// File: rtl/gdm_merge.sv
// Adds the four weight-aligned group results into the product.
module gdm_merge
  import gdm_pkg::*;
(
  input  grp_t [NGRP-1:0] grp,
  output logic [PW-1:0]   sum
);
  localparam int LO = NIB;        // first column with three group bits
  localparam int HI = 3 * NIB;    // first column of the half-adder tail

  // columns below LO hold only the low x low group
  assign sum[LO-1:0] = grp[0][LO-1:0];

  logic [HI:LO] cy_a, cy_b;
  assign cy_a[LO] = 1'b0;
  assign cy_b[LO] = 1'b0;

  for (genvar k = LO; k < HI; k++) begin : g_col
    logic third;
    if (k < OPW) begin : g_lo
      assign third = grp[0][k];
    end else begin : g_hi
      assign third = grp[3][k-OPW];
    end
    gdm_c52 u_cell (
      .x0(grp[1][k-NIB]), .x1(grp[2][k-NIB]), .x2(third),
      .ci_a(cy_a[k]), .ci_b(cy_b[k]),
      .s(sum[k]), .co_a(cy_a[k+1]), .co_b(cy_b[k+1])
    );
  end

  // tail: high x high bits plus the two carries leaving the cell row
  logic [PW-1:HI+1] t;
  gdm_fa u_t0 (.x(grp[3][HI-OPW]), .y(cy_a[HI]), .z(cy_b[HI]),
               .s(sum[HI]), .c(t[HI+1]));
  for (genvar k = HI + 1; k < PW - 1; k++) begin : g_tail
    gdm_ha u_ha (.x(grp[3][k-OPW]), .y(t[k]), .s(sum[k]), .c(t[k+1]));
  end
  // top column: the product fits in PW bits, so no carry leaves it
  assign sum[PW-1] = grp[3][PW-1-OPW] ^ t[PW-1];
endmodule

// File: rtl/gdm_mult.sv
module gdm_mult
  import gdm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic [PW-1:0]  prod_o
);
  // group index = 2*(a nibble) + (b nibble): 0 LL, 1 a-low*b-high, 2 a-high*b-low, 3 HH
  grp_t [NGRP-1:0] grp_w;
  logic [PW-1:0]   sum_w;

  for (genvar ga = 0; ga < 2; ga++) begin : g_an
    for (genvar gb = 0; gb < 2; gb++) begin : g_bn
      localparam int IDX = ga * 2 + gb;
      pp_t pp;
      gdm_ppgen u_pp (
        .a_nib(a_i[ga*NIB +: NIB]),
        .b_nib(b_i[gb*NIB +: NIB]),
        .pp(pp)
      );
      if (ga == gb) begin : g_diag
        gdm_dadda4 u_tree (.pp(pp), .res(grp_w[IDX]));
      end else begin : g_cross
        gdm_wallace4 u_tree (.pp(pp), .res(grp_w[IDX]));
      end
    end
  end

  gdm_merge u_merge (.grp(grp_w), .sum(sum_w));

  always_ff @(posedge clk) begin
    if (rst) prod_o <= '0;
    else     prod_o <= sum_w;
  end
endmodule

// File: rtl/gdm_mult_chk.sv
module gdm_mult_chk
  import gdm_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [OPW-1:0]        a_i,
  input logic [OPW-1:0]        b_i,
  input logic [PW-1:0]         prod_o,
  input grp_t [NGRP-1:0]       grp_w,
  input logic [PW-1:0]         sum_w
);
  // set once a non-reset edge has loaded the output register
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R1: registered product of the previous edge's operands
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    seen |-> prod_o == ({8'h00, $past(a_i)} * {8'h00, $past(b_i)}));

  // R3: low x low group
  p_grp_ll_r3: assert property (@(posedge clk) disable iff (rst)
    grp_w[0] == ({4'h0, a_i[3:0]} * {4'h0, b_i[3:0]}));

  // R4: high x high group
  p_grp_hh_r4: assert property (@(posedge clk) disable iff (rst)
    grp_w[3] == ({4'h0, a_i[7:4]} * {4'h0, b_i[7:4]}));

  // R5: both cross groups
  p_grp_x_r5: assert property (@(posedge clk) disable iff (rst)
    grp_w[1] == ({4'h0, a_i[3:0]} * {4'h0, b_i[7:4]}) &&
    grp_w[2] == ({4'h0, a_i[7:4]} * {4'h0, b_i[3:0]}));

  // R6: merge row equals weighted sum of the groups
  p_merge_r6: assert property (@(posedge clk) disable iff (rst)
    sum_w == ({8'h00, grp_w[0]} + ({8'h00, grp_w[1]} << 4) +
              ({8'h00, grp_w[2]} << 4) + ({8'h00, grp_w[3]} << 8)));

  // R7: zero operand gives zero product
  p_zero_r7: assert property (@(posedge clk) disable iff (rst)
    seen && ($past(a_i) == '0 || $past(b_i) == '0) |-> prod_o == '0);

  // R9: product bounded by the largest square
  p_range_r9: assert property (@(posedge clk) disable iff (rst)
    prod_o <= 16'hFE01);
endmodule

bind gdm_mult gdm_mult_chk u_chk (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i),
  .prod_o(prod_o), .grp_w(grp_w), .sum_w(sum_w)
);

// File: tb/gdm_mult_test.sv
`timescale 1ns/1ps
module gdm_mult_test;
  localparam time CLK_P = 8ns;   // 125 MHz

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a_i = 8'hFF;
  logic [7:0]  b_i = 8'hFF;
  logic [15:0] prod_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  gdm_mult uut (.clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .prod_o(prod_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge (one register away)
  task automatic one(input string req, input logic [7:0] a, input logic [7:0] b,
                     input logic [15:0] exp);
    @(negedge clk);
    a_i = a;
    b_i = b;
    @(negedge clk);
    check(req, prod_o, exp);
  endtask

  task automatic t_reset();
    // R2: reset held with all-ones operands keeps the product at zero
    repeat (3) @(negedge clk);
    check("R2", prod_o, 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_known();
    one("R6", 8'hB6, 8'h9C, 16'h6EE8);
    one("R6", 8'hF0, 8'h0F, 16'h0E10);
    one("R6", 8'hFF, 8'hFF, 16'hFE01);
    one("R1", 8'h01, 8'h01, 16'h0001);
  endtask

  task automatic t_low();
    // R3: high nibbles zero
    one("R3", 8'h0F, 8'h0F, 16'h00E1);
    one("R3", 8'h09, 8'h07, 16'h003F);
  endtask

  task automatic t_high();
    // R4: low nibbles zero
    one("R4", 8'hF0, 8'hF0, 16'hE100);
    one("R4", 8'h30, 8'hA0, 16'h1E00);
  endtask

  task automatic t_cross();
    // R5: one cross group active at a time
    one("R5", 8'h0F, 8'hF0, 16'h0E10);
    one("R5", 8'h50, 8'h0B, 16'h0370);
  endtask

  task automatic t_zero();
    // R7
    one("R7", 8'h00, 8'hFF, 16'h0000);
    one("R7", 8'hA5, 8'h00, 16'h0000);
  endtask

  task automatic t_sweep();
    // R8 exhaustive, R9 bound, pipelined one vector per cycle
    logic [15:0] exp_prev;
    bit have = 1'b0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        if (have) begin
          check("R8", prod_o, exp_prev);
          if (prod_o > 16'hFE01) check("R9", prod_o, 16'hFE01);
        end
        a_i = 8'(a);
        b_i = 8'(b);
        exp_prev = 16'(a * b);
        have = 1'b1;
      end
    end
    @(negedge clk);
    check("R8", prod_o, exp_prev);
  endtask

  initial begin
    t_reset();
    t_known();
    t_low();
    t_high();
    t_cross();
    t_zero();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule